// File: doc/BRIEF.md
# Wear-Leveling Write Redirection Controller

This unit makes placement decisions for a set-associative last-level cache built from memory cells that wear out with writes. It does not hold tags or data. The cache's lookup logic has already classified each request as a read hit, a write hit or a miss, and has found its set and way. The unit receives that classification and returns one action: service the request where the block is, redirect the write to a way in another set, or fill the returned block into a chosen way. For each set it keeps a saturating write counter. For each block it keeps a valid bit, a written bit, a relocated bit and a recency age.

The ways of every set are divided into equal, contiguous windows. For the first interval after reset all ways are ordinary. After that, one window is the reserve window and the others form the normal region, and the reserve window moves to the next index at the end of each interval. A normal-region block that is written again while it is still in its home location is moved into the reserve window of the least-written fellow set. A fellow set is one whose index matches the block's set modulo SETS/GROUP. Writes therefore move away from sets that are written heavily.

Requests enter over a valid/ready handshake, one per cycle. The response is registered and appears on the cycle after acceptance. A response that the consumer does not take with `rsp_ready` stays unchanged on the outputs. While such a response is pending, `req_ready` is low, so back-pressure passes straight to the request side.

Top module: `wl_redirect_ctrl`

## Requirements
- R1: After reset, `rsv_active` and `rsv_win` are 0 and no response is pending. For the first INTERVAL cycles no write is redirected, yet written bits and counters are still updated.
- R2: After INTERVAL clock edges out of reset, `rsv_active` is 1 and `rsv_win` is 0. After every further INTERVAL edges, `rsv_win` advances by one modulo WINDOWS. Window k covers ways k*WAYS/WINDOWS up to (k+1)*WAYS/WINDOWS-1.
- R3: A read hit (`req_kind`=0) returns in place (`rsp_act`=0) with the request's set and way and `rsp_wb`=0. It changes no counter, written bit or relocated bit. Like every other access, it makes the accessed way the most recently used.
- R4: A write hit (`req_kind`=1) to a normal-region block is redirected (`rsp_act`=2'd1) when three conditions hold: the block's written bit is set, its relocated bit is clear, and a lightly written fellow set exists. The destination becomes valid, relocated and unwritten. The source block becomes invalid with both bits cleared.
- R5: A write hit in the normal region that is not redirected is done in place. It sets the block's written bit and increments its set's counter.
- R6: A write hit to a block in the reserve window is done in place and increments its set's counter. It sets the written bit only if the relocated bit is clear.
- R7: A miss (`req_kind`=2) returns fill (`rsp_act`=2'd2) with a way outside the current reserve window, or with any way before the first rotation. The choice is the lowest-indexed invalid way first, and otherwise the way with the largest age (lowest index on a tie). `rsp_wb` is 1 when the chosen way was valid. The filled block is valid with both bits clear.
- R8: The destination way of a redirection is picked inside the target set's reserve window by the same rule as R7. `rsp_wb` is 1 when a valid victim is displaced.
- R9: The lightly written set is the fellow set other than the current one with the smallest counter, provided that counter is strictly below the current set's counter. Ties go to the lowest set index.
- R10: Counters saturate at 2**CNT_W-1. On a redirection, the destination set's counter is the one incremented.
- R11: While `rsp_valid` is 1 and `rsp_ready` is 0, all response fields hold and `req_ready` is 0. A request is accepted only on a cycle where `req_valid` and `req_ready` are both 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Request can be accepted |
| req_kind | input | 2 | 0 read hit, 1 write hit, 2 miss (3 treated as read hit) |
| req_set | input | $clog2(SETS) | Set of the request |
| req_way | input | $clog2(WAYS) | Way of the hit (ignored on a miss) |
| rsp_valid | output | 1 | Response present |
| rsp_ready | input | 1 | Consumer takes the response |
| rsp_act | output | 2 | 0 in place, 1 redirect, 2 fill |
| rsp_set | output | $clog2(SETS) | Set where the access happens |
| rsp_way | output | $clog2(WAYS) | Way where the access happens |
| rsp_wb | output | 1 | Displaced valid victim must be written back |
| rsv_active | output | 1 | A reserve window is in force |
| rsv_win | output | $clog2(WINDOWS) | Index of the reserve window |

## Verification
On every cycle the assertions check the following:
- the reserve index only ever steps by one modulo WINDOWS;
- once active, the reserve window never switches off;
- a fill never lands in the reserve window;
- a redirection target always lies in a different fellow set and inside the reserve window;
- counters never decrease;
- a stalled response holds.

Other behaviour can only be shown by the bench's scenarios:
- the redirect decision itself, which depends on the written and relocated history of a block;
- the choice of the lightest fellow, including ties;
- the order of invalid-first and oldest-way victim selection;
- saturation of counters;
- the absence of redirection during the first interval.

The bench shows these by comparing every response with a model of the per-block state.

// File: rtl/wl_pkg.sv
package wl_pkg;
  typedef enum logic [1:0] {
    K_READ  = 2'd0,
    K_WRITE = 2'd1,
    K_MISS  = 2'd2,
    K_RSVD  = 2'd3
  } req_kind_e;

  typedef enum logic [1:0] {
    A_INPLACE  = 2'd0,
    A_REDIRECT = 2'd1,
    A_FILL     = 2'd2,
    A_NONE     = 2'd3
  } rsp_act_e;
endpackage

// File: rtl/wl_window_timer.sv
module wl_window_timer #(
  parameter int INTERVAL = 64,
  parameter int WINDOWS  = 4,
  parameter int WIN_W    = (WINDOWS > 1) ? $clog2(WINDOWS) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  output logic             active,
  output logic [WIN_W-1:0] win
);
  localparam int TW = (INTERVAL > 1) ? $clog2(INTERVAL) : 1;
  localparam logic [TW-1:0]    T_LAST = TW'(INTERVAL - 1);
  localparam logic [WIN_W-1:0] W_LAST = WIN_W'(WINDOWS - 1);

  logic [TW-1:0] tmr_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tmr_q  <= '0;
      active <= 1'b0;
      win    <= '0;
    end else if (tmr_q == T_LAST) begin
      tmr_q <= '0;
      if (!active) begin
        active <= 1'b1;
        win    <= '0;
      end else begin
        win <= (win == W_LAST) ? '0 : win + 1'b1;
      end
    end else begin
      tmr_q <= tmr_q + 1'b1;
    end
  end

  // R2: the reserve index only steps round-robin
  a_r2_win_step: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(win) |-> win == (($past(win) == W_LAST) ? '0 : $past(win) + 1'b1));

  // R2: once a reserve window exists it stays in force
  a_r2_active_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    active |=> active);
endmodule

// File: rtl/wl_fellow_pick.sv
module wl_fellow_pick #(
  parameter int SETS  = 8,
  parameter int GROUP = 4,
  parameter int CNT_W = 6,
  parameter int SET_W = $clog2(SETS)
) (
  input  logic [SETS*CNT_W-1:0] cnt_flat,
  input  logic [SET_W-1:0]      cur_set,
  output logic                  light_ok,
  output logic [SET_W-1:0]      light_set
);
  localparam int STRIDE = SETS / GROUP;

  logic [CNT_W-1:0] cur_cnt;
  logic [CNT_W-1:0] best_cnt;
  logic [CNT_W-1:0] cand_cnt;

  always_comb begin
    int base;
    int cand;
    cur_cnt   = cnt_flat[int'(cur_set)*CNT_W +: CNT_W];
    base      = int'(cur_set) % STRIDE;
    light_ok  = 1'b0;
    light_set = '0;
    best_cnt  = '0;
    cand_cnt  = '0;
    for (int k = 0; k < GROUP; k++) begin
      cand     = base + k * STRIDE;
      cand_cnt = cnt_flat[cand*CNT_W +: CNT_W];
      if (cand != int'(cur_set) && cand_cnt < cur_cnt &&
          (!light_ok || cand_cnt < best_cnt)) begin
        light_ok  = 1'b1;
        best_cnt  = cand_cnt;
        light_set = SET_W'(cand);
      end
    end
  end
endmodule

// File: rtl/wl_way_pick.sv
module wl_way_pick #(
  parameter int WAYS  = 8,
  parameter int AGE_W = 4,
  parameter int WAY_W = $clog2(WAYS)
) (
  input  logic [WAYS-1:0]       valid,
  input  logic [WAYS*AGE_W-1:0] ages,
  input  logic [WAYS-1:0]       mask,
  output logic [WAY_W-1:0]      way,
  output logic                  victim_valid
);
  logic             found_inv;
  logic             have;
  logic [AGE_W-1:0] best_age;

  always_comb begin
    found_inv = 1'b0;
    have      = 1'b0;
    best_age  = '0;
    way       = '0;
    for (int i = 0; i < WAYS; i++) begin
      if (mask[i] && !valid[i] && !found_inv) begin
        found_inv = 1'b1;
        way       = WAY_W'(i);
      end
    end
    if (!found_inv) begin
      for (int i = 0; i < WAYS; i++) begin
        if (mask[i] && (!have || ages[i*AGE_W +: AGE_W] > best_age)) begin
          have     = 1'b1;
          best_age = ages[i*AGE_W +: AGE_W];
          way      = WAY_W'(i);
        end
      end
    end
    victim_valid = !found_inv;
  end
endmodule

// File: rtl/wl_redirect_ctrl.sv
module wl_redirect_ctrl #(
  parameter int SETS     = 8,
  parameter int WAYS     = 8,
  parameter int WINDOWS  = 4,
  parameter int GROUP    = 4,
  parameter int INTERVAL = 64,
  parameter int CNT_W    = 6,
  parameter int SET_W    = $clog2(SETS),
  parameter int WAY_W    = $clog2(WAYS),
  parameter int WIN_W    = (WINDOWS > 1) ? $clog2(WINDOWS) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             req_valid,
  output logic             req_ready,
  input  logic [1:0]       req_kind,
  input  logic [SET_W-1:0] req_set,
  input  logic [WAY_W-1:0] req_way,
  output logic             rsp_valid,
  input  logic             rsp_ready,
  output logic [1:0]       rsp_act,
  output logic [SET_W-1:0] rsp_set,
  output logic [WAY_W-1:0] rsp_way,
  output logic             rsp_wb,
  output logic             rsv_active,
  output logic [WIN_W-1:0] rsv_win
);
  import wl_pkg::*;

  localparam int WPW    = WAYS / WINDOWS;
  localparam int WSH    = $clog2(WPW);
  localparam int STRIDE = SETS / GROUP;
  localparam int AGE_W  = $clog2(WAYS) + 1;
  localparam logic [AGE_W-1:0] AGE_MAX = '1;
  localparam logic [CNT_W-1:0] CNT_MAX = '1;

  logic [CNT_W-1:0] cnt_q [SETS];
  logic [WAYS-1:0]  vld_q [SETS];
  logic [WAYS-1:0]  wbit_q[SETS];
  logic [WAYS-1:0]  rbit_q[SETS];
  logic [AGE_W-1:0] age_q [SETS][WAYS];

  logic [SETS*CNT_W-1:0] cnt_flat;
  logic [WAYS*AGE_W-1:0] ages_req, ages_lt;
  logic [WAYS-1:0]       rsv_mask, norm_mask;
  logic                  light_ok;
  logic [SET_W-1:0]      light_set;
  logic [WAY_W-1:0]      fill_way, rdr_way;
  logic                  fill_vv, rdr_vv;
  logic                  accept, in_rsv, do_redir;
  req_kind_e             kind;

  logic [1:0]       act_d;
  logic [SET_W-1:0] set_d;
  logic [WAY_W-1:0] way_d;
  logic             wb_d;
  logic             inc_en;
  logic [SET_W-1:0] inc_set;

  wl_window_timer #(.INTERVAL(INTERVAL), .WINDOWS(WINDOWS), .WIN_W(WIN_W)) u_tmr (
    .clk(clk), .rst_n(rst_n), .active(rsv_active), .win(rsv_win)
  );

  for (genvar gi = 0; gi < SETS; gi++) begin : g_cflat
    assign cnt_flat[gi*CNT_W +: CNT_W] = cnt_q[gi];
  end

  always_comb begin
    for (int j = 0; j < WAYS; j++) begin
      ages_req[j*AGE_W +: AGE_W] = age_q[req_set][j];
      ages_lt[j*AGE_W +: AGE_W]  = age_q[light_set][j];
      rsv_mask[j] = (WIN_W'(j >> WSH) == rsv_win);
    end
    norm_mask = rsv_active ? ~rsv_mask : '1;
  end

  wl_fellow_pick #(.SETS(SETS), .GROUP(GROUP), .CNT_W(CNT_W), .SET_W(SET_W)) u_fel (
    .cnt_flat(cnt_flat), .cur_set(req_set), .light_ok(light_ok), .light_set(light_set)
  );

  wl_way_pick #(.WAYS(WAYS), .AGE_W(AGE_W), .WAY_W(WAY_W)) u_fill_pick (
    .valid(vld_q[req_set]), .ages(ages_req), .mask(norm_mask),
    .way(fill_way), .victim_valid(fill_vv)
  );

  wl_way_pick #(.WAYS(WAYS), .AGE_W(AGE_W), .WAY_W(WAY_W)) u_rdr_pick (
    .valid(vld_q[light_set]), .ages(ages_lt), .mask(rsv_mask),
    .way(rdr_way), .victim_valid(rdr_vv)
  );

  assign req_ready = !rsp_valid || rsp_ready;
  assign accept    = req_valid && req_ready;
  assign kind      = req_kind_e'(req_kind);
  assign in_rsv    = rsv_active && rsv_mask[req_way];
  assign do_redir  = (kind == K_WRITE) && rsv_active && !in_rsv &&
                     wbit_q[req_set][req_way] && !rbit_q[req_set][req_way] && light_ok;

  always_comb begin
    act_d   = A_INPLACE;
    set_d   = req_set;
    way_d   = req_way;
    wb_d    = 1'b0;
    inc_en  = 1'b0;
    inc_set = req_set;
    case (kind)
      K_WRITE: begin
        inc_en = 1'b1;
        if (do_redir) begin
          act_d   = A_REDIRECT;
          set_d   = light_set;
          way_d   = rdr_way;
          wb_d    = rdr_vv;
          inc_set = light_set;
        end
      end
      K_MISS: begin
        act_d = A_FILL;
        way_d = fill_way;
        wb_d  = fill_vv;
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < SETS; i++) begin
        cnt_q[i]  <= '0;
        vld_q[i]  <= '0;
        wbit_q[i] <= '0;
        rbit_q[i] <= '0;
        for (int j = 0; j < WAYS; j++) age_q[i][j] <= '0;
      end
    end else if (accept) begin
      for (int i = 0; i < SETS; i++) begin
        if (inc_en && SET_W'(i) == inc_set && cnt_q[i] != CNT_MAX)
          cnt_q[i] <= cnt_q[i] + 1'b1;
        if (SET_W'(i) == set_d) begin
          for (int j = 0; j < WAYS; j++) begin
            if (WAY_W'(j) == way_d) age_q[i][j] <= '0;
            else if (age_q[i][j] != AGE_MAX) age_q[i][j] <= age_q[i][j] + 1'b1;
          end
        end
      end
      case (kind)
        K_WRITE: begin
          if (do_redir) begin
            vld_q[light_set][rdr_way]  <= 1'b1;
            rbit_q[light_set][rdr_way] <= 1'b1;
            wbit_q[light_set][rdr_way] <= 1'b0;
            vld_q[req_set][req_way]    <= 1'b0;
            wbit_q[req_set][req_way]   <= 1'b0;
            rbit_q[req_set][req_way]   <= 1'b0;
          end else if (!in_rsv || !rbit_q[req_set][req_way]) begin
            wbit_q[req_set][req_way] <= 1'b1;
          end
        end
        K_MISS: begin
          vld_q[req_set][fill_way]  <= 1'b1;
          wbit_q[req_set][fill_way] <= 1'b0;
          rbit_q[req_set][fill_way] <= 1'b0;
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;
      rsp_act   <= '0;
      rsp_set   <= '0;
      rsp_way   <= '0;
      rsp_wb    <= 1'b0;
    end else if (accept) begin
      rsp_valid <= 1'b1;
      rsp_act   <= act_d;
      rsp_set   <= set_d;
      rsp_way   <= way_d;
      rsp_wb    <= wb_d;
    end else if (rsp_ready) begin
      rsp_valid <= 1'b0;
    end
  end

  // R7: a fill never lands in the reserve window
  a_r7_fill_outside: assert property (@(posedge clk) disable iff (!rst_n)
    accept && kind == K_MISS && rsv_active |-> WIN_W'(fill_way >> WSH) != rsv_win);

  // R4, R9: a redirection target is another fellow set's reserve window
  a_r4_redir_target: assert property (@(posedge clk) disable iff (!rst_n)
    accept && do_redir |-> light_set != req_set &&
      (int'(light_set) % STRIDE) == (int'(req_set) % STRIDE) &&
      WIN_W'(rdr_way >> WSH) == rsv_win);

  // R11: a stalled response holds its value
  a_r11_rsp_hold: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid && !rsp_ready |=> rsp_valid && $stable(rsp_act) && $stable(rsp_set) &&
      $stable(rsp_way) && $stable(rsp_wb));

  // R10: counters saturate instead of wrapping
  for (genvar gs = 0; gs < SETS; gs++) begin : g_cnt_chk
    a_r10_no_wrap: assert property (@(posedge clk) disable iff (!rst_n)
      cnt_q[gs] >= $past(cnt_q[gs]));
  end
endmodule

// File: tb/sim_wl_redirect_ctrl.sv
`timescale 1ns/1ps
module sim_wl_redirect_ctrl;
  localparam int S = 8, W = 8, P = 4, G = 4, I = 64, CW = 6;
  localparam int WPW = W / P, STR = S / G, CMAX = (1 << CW) - 1, AMAX = 15;

  logic clk = 1'b0, rst_n = 1'b0;
  logic req_valid = 1'b0, rsp_ready = 1'b1;
  logic [1:0] req_kind = '0;
  logic [2:0] req_set = '0, req_way = '0;
  logic req_ready, rsp_valid, rsp_wb, rsv_active;
  logic [1:0] rsp_act, rsv_win;
  logic [2:0] rsp_set, rsp_way;

  always #2 clk = ~clk;

  wl_redirect_ctrl u0 (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_kind(req_kind), .req_set(req_set), .req_way(req_way),
    .rsp_valid(rsp_valid), .rsp_ready(rsp_ready), .rsp_act(rsp_act),
    .rsp_set(rsp_set), .rsp_way(rsp_way), .rsp_wb(rsp_wb),
    .rsv_active(rsv_active), .rsv_win(rsv_win)
  );

  int checks = 0, errors = 0, cyc = 0;
  bit mon_en = 0, done = 0;
  int cnt[S];
  bit vld[S][W], wb[S][W], rb[S][W];
  int age[S][W];

  always @(posedge clk) if (!rst_n) cyc <= 0; else cyc <= cyc + 1;

  task automatic chk(bit ok, string tag, string what, int a, int e);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0d expected=%0d", tag, what, a, e);
    end
  endtask

  // R2 rotation monitor from the bench's own cycle count
  always @(negedge clk) if (mon_en && !done) begin
    bit ea; int ew;
    ea = cyc >= I;
    ew = ea ? ((cyc / I) - 1) % P : 0;
    chk(rsv_active == ea, "R2", "rsv_active", rsv_active, ea);
    chk(int'(rsv_win) == ew, "R2", "rsv_win", rsv_win, ew);
  end

  function automatic int pick(int s, bit [W-1:0] m, output bit vw);
    int best;
    best = -1;
    for (int j = 0; j < W; j++)
      if (m[j] && !vld[s][j]) begin vw = 0; return j; end
    for (int j = 0; j < W; j++)
      if (m[j] && (best < 0 || age[s][j] > age[s][best])) best = j;
    vw = 1;
    return best;
  endfunction

  task automatic touch(int s, int w);
    for (int j = 0; j < W; j++)
      if (j == w) age[s][j] = 0; else if (age[s][j] < AMAX) age[s][j]++;
  endtask

  task automatic bump(int s, inout string tag);
    if (cnt[s] == CMAX) tag = "R10"; else cnt[s]++;
  endtask

  task automatic model(int k, int s, int w, output int ea, output int es,
                       output int ew, output int eb, output string tag);
    bit act; int win; int best; bit vw; bit [W-1:0] rm;
    act = cyc >= I;
    win = act ? ((cyc / I) - 1) % P : 0;
    for (int j = 0; j < W; j++) rm[j] = act && (j / WPW == win);
    es = s; ew = w; eb = 0; ea = 0;
    if (k == 1) begin
      best = -1;
      for (int g = 0; g < G; g++) begin
        int c; c = (s % STR) + g * STR;
        if (c != s && cnt[c] < cnt[s] && (best < 0 || cnt[c] < cnt[best])) best = c;
      end
      if (act && !rm[w] && wb[s][w] && !rb[s][w] && best >= 0) begin
        ea = 1; es = best; ew = pick(best, rm, vw); eb = vw;
        tag = vw ? "R8" : "R4/R9";
        vld[best][ew] = 1; rb[best][ew] = 1; wb[best][ew] = 0;
        vld[s][w] = 0; wb[s][w] = 0; rb[s][w] = 0;
        bump(best, tag);
      end else begin
        if (rm[w]) begin
          tag = "R6";
          if (!rb[s][w]) wb[s][w] = 1;
        end else begin
          tag = act ? "R5" : "R1";
          wb[s][w] = 1;
        end
        bump(s, tag);
      end
    end else if (k == 2) begin
      ea = 2; ew = pick(s, act ? ~rm : '1, vw); eb = vw; tag = "R7";
      vld[s][ew] = 1; wb[s][ew] = 0; rb[s][ew] = 0;
    end else begin
      tag = "R3";
    end
    touch(es, ew);
  endtask

  task automatic do_req(int k, int s, int w);
    int ea, es, ew, eb, hold; string tag;
    @(negedge clk);
    chk(req_ready == 1'b1, "R11", "req_ready idle", req_ready, 1);
    model(k, s, w, ea, es, ew, eb, tag);
    req_valid = 1; req_kind = 2'(k); req_set = 3'(s); req_way = 3'(w);
    @(negedge clk);
    req_valid = 0;
    chk(rsp_valid == 1'b1, tag, "rsp_valid", rsp_valid, 1);
    chk(int'(rsp_act) == ea && int'(rsp_set) == es && int'(rsp_way) == ew &&
        int'(rsp_wb) == eb, tag, "act/set/way/wb",
        rsp_act * 1000 + rsp_set * 100 + rsp_way * 10 + rsp_wb,
        ea * 1000 + es * 100 + ew * 10 + eb);
    hold = $urandom % 3;
    rsp_ready = (hold == 0);
    for (int h = 0; h < hold; h++) begin
      @(negedge clk);
      chk(rsp_valid && !req_ready && int'(rsp_act) == ea && int'(rsp_way) == ew &&
          int'(rsp_set) == es, "R11", "held response", rsp_act * 10 + rsp_way, ea * 10 + ew);
      if (h == hold - 1) rsp_ready = 1;
    end
  endtask

  initial begin
    int k, s, w; bit found;
    void'($urandom(32'h5eed_1234));
    for (int i = 0; i < S; i++) begin
      cnt[i] = 0;
      for (int j = 0; j < W; j++) begin vld[i][j] = 0; wb[i][j] = 0; rb[i][j] = 0; age[i][j] = 0; end
    end
    repeat (3) @(negedge clk);
    chk(rsp_valid == 0, "R1", "rsp_valid in reset", rsp_valid, 0);
    chk(rsv_active == 0, "R1", "rsv_active in reset", rsv_active, 0);
    chk(rsv_win == 0, "R1", "rsv_win in reset", rsv_win, 0);
    rst_n = 1;
    mon_en = 1;
    // R1 warm-up: fills then repeated writes stay in place
    do_req(2, 0, 0); do_req(2, 0, 0); do_req(2, 0, 0);
    do_req(1, 0, 0); do_req(1, 0, 0); do_req(0, 0, 1);
    while (cyc < I + 2) @(negedge clk);
    // R5 then R4: first write in place, second redirected to a fellow
    do_req(1, 0, 2); do_req(1, 0, 2);
    // R6 write into reserve window of the home set
    do_req(1, 0, 0);
    for (int n = 0; n < 1500; n++) begin
      k = $urandom % 10;
      found = 0;
      if (k < 8) begin
        for (int t = 0; t < 30 && !found; t++) begin
          s = $urandom % S; w = $urandom % W;
          if (vld[s][w]) found = 1;
        end
      end
      if (found) do_req(k < 4 ? 0 : 1, s, w);
      else do_req(2, $urandom % S, 0);
    end
    repeat (2) @(negedge clk);
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      done = 1;
      checks++; errors++;
      $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule